// File: doc/BRIEF.md
# Three-Share Masked 64-bit Block Cipher Core

The core encrypts one 64-bit block under an 80-bit key. The block is held as three Boolean shares, and their XOR is the true value. It runs an iterative substitution-permutation network of 31 rounds. Each round has a key mix, a nonlinear layer of sixteen 4-bit substitutions, and a fixed bit permutation. A last whitening key closes the run. The key schedule is not masked and produces the round keys one round at a time.

The key touches share 1 only. The permutation is linear, so it runs on each share by itself. The nonlinear layer is a two-stage shared substitution with three shares in and three shares out. Each output share of a stage depends on two input shares only, never on all three. The quadratic half-substitution F is applied twice, with an affine map between the two applications. So a round takes four cycles: key mix, stage one, stage two, permutation.

A caller pulses `start` with the plaintext shares and the key. It waits for a one-cycle `done` pulse and reads three ciphertext shares. Their XOR is the ciphertext. Producing the masks and refreshing them is left to the surrounding logic.

Top module: `mask3_spn64_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` is 0 and all three ciphertext shares are 0.
- R2: The XOR of the three output shares equals the unmasked encryption of the XOR of the three input shares. The encryption is defined as follows.
  - The 80-bit key register starts at the key.
  - Each of the 31 rounds XORs the top 64 key bits into the state.
  - It then applies the 4-bit substitution C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (indexed 0 to F) to every nibble.
  - It then moves bit i to bit 16·i mod 63, with bit 63 fixed.
  - It then updates the key in three steps: rotate left by 61, substitute the top nibble, and XOR the round number (1 to 31) into bits 19..15.
  - After round 31, the top 64 key bits are XORed in once more.
- R3: For a fixed plaintext and key, the recombined result does not depend on how the plaintext is split into shares.
- R4: `done` goes high in the cycle that follows the 125th rising edge after the edge that samples `start` in the idle state.
- R5: `done` is high for exactly one cycle per encryption.
- R6: While the core is idle, the output shares hold their values until the next accepted `start`. A `start` pulse, or new input values, during a run have no effect on that run's result or latency.
- R7: Key material is XORed into share 1 only, and only in key-mix cycles. The key register changes only in permutation cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an encryption (sampled when idle) |
| pt_sh1 | input | 64 | Plaintext share 1 |
| pt_sh2 | input | 64 | Plaintext share 2 |
| pt_sh3 | input | 64 | Plaintext share 3 |
| key_in | input | 80 | Cipher key |
| done | output | 1 | One-cycle completion pulse |
| ct_sh1 | output | 64 | Ciphertext share 1 |
| ct_sh2 | output | 64 | Ciphertext share 2 |
| ct_sh3 | output | 64 | Ciphertext share 3 |

## Verification
The properties assume that `start` is only meaningful when the core is idle. They also assume that the input buses need not stay stable during a run, because the core captures them once. The stimulus keeps to this: it raises `start` for one cycle per encryption and drives inputs on the falling edge. It deliberately pulses `start` and changes every input in the middle of one run, to show that the run is unaffected. The masks come from a uniform random source, so the recombination checks cover many splittings of the same value.

// File: rtl/mask3_pkg.sv
package mask3_pkg;

    localparam int unsigned BLK_W    = 64;
    localparam int unsigned KEY_W    = 80;
    localparam int unsigned NIB_W    = 4;
    localparam int unsigned ROUNDS   = 31;
    localparam int unsigned RND_W    = $clog2(ROUNDS + 1);
    localparam int unsigned RK_LSB   = KEY_W - BLK_W;

    // Nibble tables, entry 0 in the most significant nibble.
    localparam logic [63:0] SUB_TBL  = 64'hC56B90AD3EF84712;
    localparam logic [63:0] HALF_TBL = 64'hC905AF8D63EB4127;
    localparam logic [63:0] AFF_TBL  = 64'h8FDACB9E43160752;

    function automatic logic [3:0] nib_lookup(input logic [63:0] tbl, input logic [3:0] idx);
        return tbl[{~idx, 2'b00} +: 4];
    endfunction

    function automatic int unsigned perm_dest(input int unsigned src, input int unsigned width);
        if (src == width - 1) return src;
        return (src * (width / 4)) % (width - 1);
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE, ST_KEYADD, ST_SBOX1, ST_SBOX2, ST_PERM, ST_FINAL
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e         fsm;
        logic [RND_W-1:0]   rnd;
        logic [KEY_W-1:0]   key;
        logic [BLK_W-1:0]   s1;
        logic [BLK_W-1:0]   s2;
        logic [BLK_W-1:0]   s3;
        logic               done;
    } core_regs_t;

endpackage

// File: rtl/mask3_share_fn.sv
// One component of the shared quadratic map F for a single nibble.
// It uses two input shares only: F(xi^xj) ^ F(xj) ^ F(0).
// Optionally the affine map is applied to the result.
module mask3_share_fn
    import mask3_pkg::*;
#(
    parameter bit APPLY_AFF = 1'b0
) (
    input  logic [NIB_W-1:0] xi,
    input  logic [NIB_W-1:0] xj,
    output logic [NIB_W-1:0] y
);
    localparam logic [3:0] F_AT_ZERO = nib_lookup(HALF_TBL, 4'h0);

    logic [NIB_W-1:0] comp;

    always_comb begin
        comp = nib_lookup(HALF_TBL, xi ^ xj) ^ nib_lookup(HALF_TBL, xj) ^ F_AT_ZERO;
    end

    generate
        if (APPLY_AFF) begin : g_aff
            assign y = nib_lookup(AFF_TBL, comp);
        end else begin : g_plain
            assign y = comp;
        end
    endgenerate
endmodule

// File: rtl/mask3_nl_layer.sv
// One stage of the three-share nonlinear layer across the whole block.
module mask3_nl_layer
    import mask3_pkg::*;
#(
    parameter int unsigned WIDTH     = BLK_W,
    parameter bit          APPLY_AFF = 1'b0
) (
    input  logic [WIDTH-1:0] a1,
    input  logic [WIDTH-1:0] a2,
    input  logic [WIDTH-1:0] a3,
    output logic [WIDTH-1:0] y1,
    output logic [WIDTH-1:0] y2,
    output logic [WIDTH-1:0] y3
);
    localparam int unsigned NNIB = WIDTH / NIB_W;

    generate
        for (genvar n = 0; n < NNIB; n++) begin : g_nib
            // Output share k never sees input share k.
            mask3_share_fn #(.APPLY_AFF(APPLY_AFF)) u_c1 (
                .xi(a2[n*NIB_W +: NIB_W]), .xj(a3[n*NIB_W +: NIB_W]), .y(y1[n*NIB_W +: NIB_W]));
            mask3_share_fn #(.APPLY_AFF(APPLY_AFF)) u_c2 (
                .xi(a3[n*NIB_W +: NIB_W]), .xj(a1[n*NIB_W +: NIB_W]), .y(y2[n*NIB_W +: NIB_W]));
            mask3_share_fn #(.APPLY_AFF(APPLY_AFF)) u_c3 (
                .xi(a1[n*NIB_W +: NIB_W]), .xj(a2[n*NIB_W +: NIB_W]), .y(y3[n*NIB_W +: NIB_W]));
        end
    endgenerate
endmodule

// File: rtl/mask3_perm.sv
// Bit permutation, applied to one share.
module mask3_perm
    import mask3_pkg::*;
#(
    parameter int unsigned WIDTH = BLK_W
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            localparam int unsigned DST = perm_dest(i, WIDTH);
            assign dout[DST] = din[i];
        end
    endgenerate
endmodule

// File: rtl/mask3_keysched.sv
// Next key register value: rotate, substitute top nibble, add round count.
module mask3_keysched
    import mask3_pkg::*;
#(
    parameter int unsigned KW   = KEY_W,
    parameter int unsigned ROT  = 61,
    parameter int unsigned CLSB = 15
) (
    input  logic [KW-1:0]    key_cur,
    input  logic [RND_W-1:0] rnd,
    output logic [KW-1:0]    key_nxt
);
    logic [KW-1:0] rot;

    always_comb begin
        rot = (key_cur << ROT) | (key_cur >> (KW - ROT));
        key_nxt = rot;
        key_nxt[KW-1 -: NIB_W] = nib_lookup(SUB_TBL, rot[KW-1 -: NIB_W]);
        key_nxt[CLSB +: RND_W] = rot[CLSB +: RND_W] ^ rnd;
    end
endmodule

// File: rtl/mask3_spn64_core.sv
module mask3_spn64_core
    import mask3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  pt_sh1,
    input  logic [BLK_W-1:0]  pt_sh2,
    input  logic [BLK_W-1:0]  pt_sh3,
    input  logic [KEY_W-1:0]  key_in,
    output logic              done,
    output logic [BLK_W-1:0]  ct_sh1,
    output logic [BLK_W-1:0]  ct_sh2,
    output logic [BLK_W-1:0]  ct_sh3
);
    core_regs_t r_q, r_d;

    logic [BLK_W-1:0] st1_y1, st1_y2, st1_y3;
    logic [BLK_W-1:0] st2_y1, st2_y2, st2_y3;
    logic [BLK_W-1:0] pm1, pm2, pm3;
    logic [KEY_W-1:0] key_nxt;
    logic [BLK_W-1:0] rkey;

    assign rkey = r_q.key[KEY_W-1:RK_LSB];

    mask3_nl_layer #(.WIDTH(BLK_W), .APPLY_AFF(1'b1)) u_stage1 (
        .a1(r_q.s1), .a2(r_q.s2), .a3(r_q.s3), .y1(st1_y1), .y2(st1_y2), .y3(st1_y3));

    mask3_nl_layer #(.WIDTH(BLK_W), .APPLY_AFF(1'b0)) u_stage2 (
        .a1(r_q.s1), .a2(r_q.s2), .a3(r_q.s3), .y1(st2_y1), .y2(st2_y2), .y3(st2_y3));

    mask3_perm #(.WIDTH(BLK_W)) u_perm1 (.din(r_q.s1), .dout(pm1));
    mask3_perm #(.WIDTH(BLK_W)) u_perm2 (.din(r_q.s2), .dout(pm2));
    mask3_perm #(.WIDTH(BLK_W)) u_perm3 (.din(r_q.s3), .dout(pm3));

    mask3_keysched u_ks (.key_cur(r_q.key), .rnd(r_q.rnd), .key_nxt(key_nxt));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.fsm)
            ST_IDLE: begin
                if (start) begin
                    r_d.s1  = pt_sh1;
                    r_d.s2  = pt_sh2;
                    r_d.s3  = pt_sh3;
                    r_d.key = key_in;
                    r_d.rnd = RND_W'(1);
                    r_d.fsm = ST_KEYADD;
                end
            end
            ST_KEYADD: begin
                r_d.s1  = r_q.s1 ^ rkey;
                r_d.fsm = ST_SBOX1;
            end
            ST_SBOX1: begin
                r_d.s1  = st1_y1;
                r_d.s2  = st1_y2;
                r_d.s3  = st1_y3;
                r_d.fsm = ST_SBOX2;
            end
            ST_SBOX2: begin
                r_d.s1  = st2_y1;
                r_d.s2  = st2_y2;
                r_d.s3  = st2_y3;
                r_d.fsm = ST_PERM;
            end
            ST_PERM: begin
                r_d.s1  = pm1;
                r_d.s2  = pm2;
                r_d.s3  = pm3;
                r_d.key = key_nxt;
                if (r_q.rnd == RND_W'(ROUNDS)) begin
                    r_d.fsm = ST_FINAL;
                end else begin
                    r_d.rnd = r_q.rnd + RND_W'(1);
                    r_d.fsm = ST_KEYADD;
                end
            end
            ST_FINAL: begin
                r_d.s1   = r_q.s1 ^ rkey;
                r_d.done = 1'b1;
                r_d.fsm  = ST_IDLE;
            end
            default: r_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.fsm  <= ST_IDLE;
            r_q.rnd  <= RND_W'(1);
            r_q.key  <= '0;
            r_q.s1   <= '0;
            r_q.s2   <= '0;
            r_q.s3   <= '0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done   = r_q.done;
    assign ct_sh1 = r_q.s1;
    assign ct_sh2 = r_q.s2;
    assign ct_sh3 = r_q.s3;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == ST_IDLE && !start) |=> ($stable(ct_sh1) && $stable(ct_sh2) && $stable(ct_sh3)));

    // R7
    key_one_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == ST_KEYADD || r_q.fsm == ST_FINAL) |=> ($stable(r_q.s2) && $stable(r_q.s3)));

    // R7
    key_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm != ST_PERM && r_q.fsm != ST_IDLE) |=> $stable(r_q.key));

    // R4
    round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.rnd >= RND_W'(1)) && (r_q.rnd <= RND_W'(ROUNDS)));

    // R4
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (r_q.fsm == ST_IDLE && $past(r_q.rnd) == RND_W'(ROUNDS)));

endmodule

// File: tb/mask3_spn64_core_tb.sv
module mask3_spn64_core_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  EXP_LAT    = 125;
    localparam int  WDOG_CYC   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] pt_sh1 = '0, pt_sh2 = '0, pt_sh3 = '0;
    logic [79:0] key_in = '0;
    logic        done;
    logic [63:0] ct_sh1, ct_sh2, ct_sh3;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // {plaintext, key, ciphertext}
    localparam logic [207:0] VECS [4] = '{
        {64'h0000000000000000, 80'h00000000000000000000, 64'h5579C1387B228445},
        {64'h0000000000000000, 80'hFFFFFFFFFFFFFFFFFFFF, 64'hE72C46C0F5945049},
        {64'hFFFFFFFFFFFFFFFF, 80'h00000000000000000000, 64'hA112FFC72F68417B},
        {64'hFFFFFFFFFFFFFFFF, 80'hFFFFFFFFFFFFFFFFFFFF, 64'h3333DCD3213210D2}
    };

    mask3_spn64_core u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pt_sh1(pt_sh1), .pt_sh2(pt_sh2), .pt_sh3(pt_sh3), .key_in(key_in),
        .done(done), .ct_sh1(ct_sh1), .ct_sh2(ct_sh2), .ct_sh3(ct_sh3));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] ref_sub(input logic [3:0] v);
        case (v)
            4'h0: return 4'hC; 4'h1: return 4'h5; 4'h2: return 4'h6; 4'h3: return 4'hB;
            4'h4: return 4'h9; 4'h5: return 4'h0; 4'h6: return 4'hA; 4'h7: return 4'hD;
            4'h8: return 4'h3; 4'h9: return 4'hE; 4'hA: return 4'hF; 4'hB: return 4'h8;
            4'hC: return 4'h4; 4'hD: return 4'h7; 4'hE: return 4'h1; default: return 4'h2;
        endcase
    endfunction

    function automatic logic [63:0] ref_enc(input logic [63:0] p, input logic [79:0] k);
        logic [63:0] st, t;
        logic [79:0] ky;
        st = p;
        ky = k;
        for (int r = 1; r <= 31; r++) begin
            st = st ^ ky[79:16];
            for (int n = 0; n < 16; n++) t[4*n +: 4] = ref_sub(st[4*n +: 4]);
            for (int b = 0; b < 64; b++) st[(b == 63) ? 63 : (b * 16) % 63] = t[b];
            ky = {ky[18:0], ky[79:19]};
            ky[79:76] = ref_sub(ky[79:76]);
            ky[19:15] = ky[19:15] ^ 5'(r);
        end
        return st ^ ky[79:16];
    endfunction

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_enc(input logic [63:0] p, input logic [63:0] m1, input logic [63:0] m2,
                           input logic [79:0] k, input bit disturb,
                           output logic [63:0] res, output int lat);
        @(negedge clk);
        pt_sh1 = p ^ m1 ^ m2;
        pt_sh2 = m1;
        pt_sh3 = m2;
        key_in = k;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 400) begin
            if (disturb && lat == 40) begin
                start  = 1'b1;
                pt_sh1 = ~pt_sh1;
                pt_sh2 = pt_sh2 ^ 64'h0123456789ABCDEF;
                key_in = ~key_in;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        res = ct_sh1 ^ ct_sh2 ^ ct_sh3;
    endtask

    initial begin : watchdog
        while (cycles < WDOG_CYC) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL R4 watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [63:0] res, res2, p, m1, m2, h1, h2, h3;
        logic [79:0] k;
        int lat;

        // R1: reset state, during reset and after release
        repeat (3) @(negedge clk);
        chk("R1 done in reset", 80'(done), 80'(0));
        chk("R1 shares in reset", 80'(ct_sh1 | ct_sh2 | ct_sh3), 80'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 80'(done), 80'(0));
        chk("R1 shares after reset", 80'(ct_sh1 | ct_sh2 | ct_sh3), 80'(0));

        // R2 R7: known vectors, random masks
        foreach (VECS[i]) begin
            run_enc(VECS[i][207:144], 64'($urandom) << 32 | 64'($urandom),
                    64'($urandom) << 32 | 64'($urandom), VECS[i][143:64], 1'b0, res, lat);
            chk("R2 R7 vector result", 80'(res), 80'(VECS[i][63:0]));
            chk("R4 latency", 80'(lat), 80'(EXP_LAT));
            @(negedge clk);
            chk("R5 done single cycle", 80'(done), 80'(0));
        end

        // R2: random keys, plaintexts, masks against the unmasked model
        for (int i = 0; i < 6; i++) begin
            p  = {$urandom, $urandom};
            m1 = {$urandom, $urandom};
            m2 = {$urandom, $urandom};
            k  = {16'($urandom), $urandom, $urandom};
            run_enc(p, m1, m2, k, 1'b0, res, lat);
            chk("R2 random result", 80'(res), 80'(ref_enc(p, k)));
        end

        // R3: same value, different splittings
        p = 64'hDEADBEEF01234567;
        k = 80'h0F1E2D3C4B5A69788796;
        run_enc(p, 64'h0, 64'h0, k, 1'b0, res, lat);
        run_enc(p, 64'hA5A5A5A5A5A5A5A5, 64'h3C3C3C3C3C3C3C3C, k, 1'b0, res2, lat);
        chk("R3 mask independence", 80'(res2), 80'(res));
        chk("R3 model", 80'(res), 80'(ref_enc(p, k)));

        // R6: start and input changes mid-run are ignored
        p = 64'h1122334455667788;
        k = 80'h99AABBCCDDEEFF001122;
        run_enc(p, 64'h5555AAAA5555AAAA, 64'h0F0F0F0F0F0F0F0F, k, 1'b1, res, lat);
        chk("R6 mid-run start result", 80'(res), 80'(ref_enc(p, k)));
        chk("R6 mid-run start latency", 80'(lat), 80'(EXP_LAT));

        // R6: outputs held while idle with changing inputs
        h1 = ct_sh1; h2 = ct_sh2; h3 = ct_sh3;
        pt_sh1 = ~pt_sh1; pt_sh2 = ~pt_sh2; pt_sh3 = ~pt_sh3; key_in = ~key_in;
        repeat (5) @(negedge clk);
        chk("R6 hold share1", 80'(ct_sh1), 80'(h1));
        chk("R6 hold share2", 80'(ct_sh2), 80'(h2));
        chk("R6 hold share3", 80'(ct_sh3), 80'(h3));
        chk("R5 no spurious done", 80'(done), 80'(0));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule